// File: doc/BRIEF.md
# Stop-Mode Recovery Controller

This block brings a small 8-bit controller core back from its low-power stop state. Software programs one control register in the expanded register space. The register sets which input may wake the part, whether that input wakes on a low level or a high level, how long the core is held in reset after the wake, and the internal clock divide setting. The block drives the clock gate for as long as the core is stopped.

In stop, the block watches the chosen wake input. A wake level is only accepted once it has been held for a minimum number of clock cycles. A watchdog timeout that arrives during stop wakes the part at once. On a valid wake the block opens the clock gate and raises a recovery reset for the programmed time. It also sets a sticky flag that software can read. The flag separates a recovery reset from a power-on reset. A recovery reset keeps the control register contents. A power-on reset clears them.

The wake inputs and the watchdog timeout are expected to be synchronous to `clk`. The clock is the always-on oscillator.

Top module: `smr_ctrl`

## Requirements
- R1: After a power-on reset (`rst_n` low at a clock edge), the control register is 0, the flag is 0, `bus_rdata` reads 8'h00, and `clk_div`, `stop_clk_gate` and `rec_reset` are all 0.
- R2: A write with `bus_we`=1, `bus_bank`=4'hF and `bus_addr`=8'h0B loads `bus_wdata[6:0]` into the control register. A write to any other bank or address changes nothing.
- R3: Reading bank 4'hF, address 8'h0B returns the flag in bit 7 and 0 in bits 6:0. Writing bit 7 has no effect on the flag.
- R4: `clk_div` always equals control bits 1:0.
- R5: A `stop_req` pulse while running sets `stop_clk_gate` at the next clock edge.
- R6: Control bits 4:2 select the wake source. Code 000 selects `wake_pin`, and only when `wake_pin_is_input`=1. Code k (1 to 7) selects `port_in[k-1]`. Inputs that are not selected are ignored.
- R7: Control bit 6 sets the wake level. 0 means the source wakes when low; 1 means it wakes when high.
- R8: A wake is accepted at the TWSM-th consecutive clock edge that samples the source at its wake level (TWSM=4). Shorter pulses are ignored.
- R9: A `wdt_timeout` sampled in stop wakes the part at that edge, whatever source is selected. Outside stop it is ignored.
- R10: On a wake, `stop_clk_gate` falls and `rec_reset` rises at the same edge. `rec_reset` then stays high for exactly 16 cycles when control bit 5 is 0, or 1024 cycles when it is 1. After that the block returns to run.
- R11: The flag is set at the wake edge. It stays set through later stop entries and recoveries, and only a power-on reset clears it.
- R12: A recovery reset keeps the control register contents, including `clk_div`.
- R13: A watchdog timeout that lands in the same cycle the pin filter completes gives a single recovery of the programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| bus_bank | input | 4 | Expanded register bank select |
| bus_addr | input | 8 | Register address within the bank |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data: flag in bit 7 |
| stop_req | input | 1 | One-cycle request to enter stop |
| wake_pin | input | 1 | Fixed wake pin |
| wake_pin_is_input | input | 1 | Fixed pin is configured as an input |
| port_in | input | 7 | Selectable port wake inputs |
| wdt_timeout | input | 1 | Watchdog timeout pulse |
| stop_clk_gate | output | 1 | 1 while core clocks are stopped |
| rec_reset | output | 1 | Recovery reset to the core |
| rec_flag | output | 1 | Sticky recovery flag |
| clk_div | output | 2 | Internal clock divide setting |

## Verification
Two wake causes can arrive in the same cycle: the pin filter reaching its TWSM-th active sample, and a watchdog timeout. The bench holds the fixed pin low for four edges and raises `wdt_timeout` on the fourth edge only. It then counts the cycles in which `rec_reset` is high. The count must be exactly 16, which shows the delay was neither restarted nor doubled. `stop_clk_gate` must be low once the count ends.

// File: rtl/smr_pkg.sv
// Shared types and field positions for the stop-mode recovery controller.
package smr_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STOP    = 2'd1,
        ST_RECOVER = 2'd2
    } smr_state_e;

    localparam int CTRL_BITS = 7;   // writable control bits 6:0
    localparam int POL_BIT   = 6;
    localparam int DLY_BIT   = 5;
    localparam int SRC_LSB   = 2;
    localparam int SRC_MSB   = 4;
    localparam int DIV_LSB   = 0;
    localparam int DIV_MSB   = 1;
endpackage

// File: rtl/smr_regs.sv
// Control register and sticky recovery flag.
// Decodes one bank/address pair, stores bits 6:0 and returns the flag in bit 7.
// Assumes rst_n is the power-on reset; a recovery never clears these bits.
module smr_regs
    import smr_pkg::*;
#(
    parameter logic [3:0] BANK_ID  = 4'hF,
    parameter logic [7:0] REG_ADDR = 8'h0B
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           bus_bank,
    input  logic [7:0]           bus_addr,
    input  logic                 bus_we,
    input  logic [7:0]           bus_wdata,
    input  logic                 wake_evt,
    output logic [CTRL_BITS-1:0] ctrl_q,
    output logic                 flag_q,
    output logic [7:0]           bus_rdata
);
    logic hit;
    logic wr_hit;
    logic unused_wbit;

    // Address decode for the single register.
    assign hit         = (bus_bank == BANK_ID) && (bus_addr == REG_ADDR);
    assign wr_hit      = hit && bus_we;
    assign unused_wbit = bus_wdata[7];

    // Writable control bits: cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (wr_hit) ctrl_q <= bus_wdata[CTRL_BITS-1:0];
    end

    // Sticky flag: set by hardware on wake, cleared only by power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (wake_evt) flag_q <= 1'b1;
    end

    // Read path: only the flag is readable; other bits read as zero.
    always_comb begin
        bus_rdata = 8'h00;
        if (hit) bus_rdata[7] = flag_q;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |=> flag_q);                                   // R11
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(ctrl_q));                         // R2
endmodule

// File: rtl/smr_wake_detect.sv
// Wake source selection, level polarity and minimum pulse-width filter.
// Assumes inputs are synchronous to clk and TWSM >= 2.
module smr_wake_detect #(
    parameter int TWSM  = 4,
    parameter int NPORT = 7,
    localparam int SEL_W = $clog2(NPORT + 1),
    localparam int CNT_W = $clog2(TWSM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_stop,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             pol_high,
    input  logic             fixed_pin,
    input  logic             fixed_is_input,
    input  logic [NPORT-1:0] port_in,
    output logic             pin_wake
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TWSM - 1);

    logic             src_lvl;
    logic             src_active;
    logic [CNT_W-1:0] cnt_q;

    // Source multiplexer: code 0 is the fixed pin, code k is port_in[k-1].
    always_comb begin
        src_lvl = !pol_high;   // inactive level by default
        if (src_sel == '0) begin
            if (fixed_is_input) src_lvl = fixed_pin;
        end else begin
            for (int i = 0; i < NPORT; i++) begin
                if (src_sel == SEL_W'(i + 1)) src_lvl = port_in[i];
            end
        end
    end

    // Polarity: compare the source with the programmed wake level.
    assign src_active = (src_lvl == pol_high);

    // Consecutive-active counter, running only during stop.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_stop)  cnt_q <= '0;
        else if (!src_active)    cnt_q <= '0;
        else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
    end

    // Wake on the TWSM-th consecutive active sample.
    assign pin_wake = in_stop && src_active && (cnt_q == LAST);

    AST_MIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pin_wake |-> $past(src_active) && $past(in_stop));    // R8
endmodule

// File: rtl/smr_sequencer.sv
// Run/stop/recover state machine with programmable post-wake reset delay.
// Assumes stop_req is a one-cycle request from the core while it runs.
module smr_sequencer
    import smr_pkg::*;
#(
    parameter int SHORT_EXP = 4,
    parameter int LONG_EXP  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic pin_wake,
    input  logic wdt_timeout,
    input  logic long_dly,
    output logic wake_evt,
    output logic stop_clk_gate,
    output logic rec_reset
);
    localparam logic [LONG_EXP-1:0] SHORT_LAST = LONG_EXP'((1 << SHORT_EXP) - 1);
    localparam logic [LONG_EXP-1:0] LONG_LAST  = LONG_EXP'((1 << LONG_EXP) - 1);

    smr_state_e          state_q;
    logic [LONG_EXP-1:0] dly_q;
    logic [LONG_EXP-1:0] dly_last;

    // Wake from either cause, only while stopped.
    assign wake_evt = (state_q == ST_STOP) && (pin_wake || wdt_timeout);
    assign dly_last = long_dly ? LONG_LAST : SHORT_LAST;

    // State transitions and delay counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            dly_q   <= '0;
        end else begin
            unique case (state_q)
                ST_RUN: if (stop_req) state_q <= ST_STOP;
                ST_STOP: if (wake_evt) begin
                    state_q <= ST_RECOVER;
                    dly_q   <= '0;
                end
                ST_RECOVER: begin
                    if (dly_q == dly_last) state_q <= ST_RUN;
                    else                   dly_q   <= dly_q + 1'b1;
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // Registered-state outputs.
    assign stop_clk_gate = (state_q == ST_STOP);
    assign rec_reset     = (state_q == ST_RECOVER);

    AST_GATE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_clk_gate && rec_reset));                       // R10
    AST_REC_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_reset) |-> $past(stop_clk_gate));           // R9
endmodule

// File: rtl/smr_ctrl.sv
// Top of the stop-mode recovery controller: register, wake filter, sequencer.
// Assumes all inputs are synchronous to the always-on clock.
module smr_ctrl
    import smr_pkg::*;
#(
    parameter int         TWSM      = 4,
    parameter int         NPORT     = 7,
    parameter int         SHORT_EXP = 4,
    parameter int         LONG_EXP  = 10,
    parameter logic [3:0] BANK_ID   = 4'hF,
    parameter logic [7:0] REG_ADDR  = 8'h0B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       bus_bank,
    input  logic [7:0]       bus_addr,
    input  logic             bus_we,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             stop_req,
    input  logic             wake_pin,
    input  logic             wake_pin_is_input,
    input  logic [NPORT-1:0] port_in,
    input  logic             wdt_timeout,
    output logic             stop_clk_gate,
    output logic             rec_reset,
    output logic             rec_flag,
    output logic [1:0]       clk_div
);
    localparam int SEL_W = $clog2(NPORT + 1);

    logic [CTRL_BITS-1:0] ctrl;
    logic                 wake_evt;
    logic                 pin_wake;
    logic [SEL_W-1:0]     src_sel;

    assign src_sel = SEL_W'(ctrl[SRC_MSB:SRC_LSB]);
    assign clk_div = ctrl[DIV_MSB:DIV_LSB];

    smr_regs #(.BANK_ID(BANK_ID), .REG_ADDR(REG_ADDR)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_bank  (bus_bank),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .wake_evt  (wake_evt),
        .ctrl_q    (ctrl),
        .flag_q    (rec_flag),
        .bus_rdata (bus_rdata)
    );

    smr_wake_detect #(.TWSM(TWSM), .NPORT(NPORT)) u_wake (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_stop        (stop_clk_gate),
        .src_sel        (src_sel),
        .pol_high       (ctrl[POL_BIT]),
        .fixed_pin      (wake_pin),
        .fixed_is_input (wake_pin_is_input),
        .port_in        (port_in),
        .pin_wake       (pin_wake)
    );

    smr_sequencer #(.SHORT_EXP(SHORT_EXP), .LONG_EXP(LONG_EXP)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .stop_req      (stop_req),
        .pin_wake      (pin_wake),
        .wdt_timeout   (wdt_timeout),
        .long_dly      (ctrl[DLY_BIT]),
        .wake_evt      (wake_evt),
        .stop_clk_gate (stop_clk_gate),
        .rec_reset     (rec_reset)
    );

    AST_FLAG_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_reset) |-> rec_flag);                       // R11
    AST_DIV_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_reset) |-> $stable(clk_div));               // R12
endmodule

// File: tb/tb_smr_ctrl.sv
module tb_smr_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_bank = 4'hF;
    logic [7:0] bus_addr = 8'h0B;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       stop_req = 1'b0;
    logic       wake_pin = 1'b1;
    logic       wake_pin_is_input = 1'b1;
    logic [6:0] port_in = 7'h7F;
    logic       wdt_timeout = 1'b0;
    logic       stop_clk_gate, rec_reset, rec_flag;
    logic [1:0] clk_div;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;   // 250 MHz

    smr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_bank(bus_bank), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stop_req(stop_req), .wake_pin(wake_pin),
        .wake_pin_is_input(wake_pin_is_input), .port_in(port_in),
        .wdt_timeout(wdt_timeout), .stop_clk_gate(stop_clk_gate),
        .rec_reset(rec_reset), .rec_flag(rec_flag), .clk_div(clk_div)
    );

    // Vector: {ctrl[6:0], hold[7:0], pin_is_input, drive_neighbour, expect_wake}
    localparam logic [17:0] VEC [8] = '{
        {7'h00, 8'd4, 1'b1, 1'b0, 1'b1},
        {7'h00, 8'd3, 1'b1, 1'b0, 1'b0},
        {7'h00, 8'd4, 1'b0, 1'b0, 1'b0},
        {7'h40, 8'd4, 1'b1, 1'b0, 1'b1},
        {7'h0D, 8'd4, 1'b1, 1'b0, 1'b1},
        {7'h0C, 8'd6, 1'b1, 1'b1, 1'b0},
        {7'h5C, 8'd5, 1'b1, 1'b0, 1'b1},
        {7'h44, 8'd2, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic por();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(logic [3:0] bank, logic [7:0] addr, logic [7:0] data);
        bus_bank = bank; bus_addr = addr; bus_wdata = data; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_bank = 4'hF; bus_addr = 8'h0B;
    endtask

    task automatic enter_stop();
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        chk("R5 gate after stop_req", int'(stop_clk_gate), 1);
    endtask

    // Drive all wake inputs inactive, or the chosen one active.
    task automatic drive(logic [2:0] sel, logic pol, logic alt, logic act);
        wake_pin = ~pol;
        port_in  = {7{~pol}};
        if (act) begin
            if (sel == 3'd0) wake_pin = pol;
            else port_in[(int'(sel) - 1 + int'(alt)) % 7] = pol;
        end
    endtask

    function automatic int rec_len();
        int n = 0;
        return n;
    endfunction

    task automatic count_rec(output int n);
        n = 0;
        while (rec_reset && n < 3000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        @(negedge clk);
        por();
        // R1: reset state
        chk("R1 rdata", int'(bus_rdata), 0);
        chk("R1 gate", int'(stop_clk_gate), 0);
        chk("R1 rec_reset", int'(rec_reset), 0);
        chk("R1 clk_div", int'(clk_div), 0);

        // R2/R3/R4: decode, read-only flag, divider
        wr(4'hE, 8'h0B, 8'h03);
        chk("R2 wrong bank ignored", int'(clk_div), 0);
        wr(4'hF, 8'h0A, 8'h03);
        chk("R2 wrong addr ignored", int'(clk_div), 0);
        wr(4'hF, 8'h0B, 8'h82);
        chk("R4 clk_div", int'(clk_div), 2);
        chk("R3 bit7 write ignored", int'(bus_rdata), 0);

        // Vector table: source, polarity, pulse width
        for (int i = 0; i < 8; i++) begin
            logic [6:0] c;
            int         hold;
            c    = VEC[i][17:11];
            hold = int'(VEC[i][10:3]);
            por();
            wake_pin_is_input = VEC[i][2];
            drive(c[4:2], c[6], 1'b0, 1'b0);
            wr(4'hF, 8'h0B, {1'b0, c});
            chk("R4 clk_div vector", int'(clk_div), int'(c[1:0]));
            enter_stop();
            drive(c[4:2], c[6], VEC[i][1], 1'b1);
            repeat (hold) @(negedge clk);
            // R6 R7 R8: wake only on selected source, right level, full width
            chk($sformatf("R8 R6 R7 vector %0d wake", i), int'(rec_reset), int'(VEC[i][0]));
            drive(c[4:2], c[6], 1'b0, 1'b0);
            if (VEC[i][0]) begin
                count_rec(n);
                chk("R11 flag after vector wake", int'(bus_rdata), 8'h80);
            end else begin
                chk("R6 still stopped", int'(stop_clk_gate), 1);
            end
        end
        wake_pin_is_input = 1'b1;

        // R9: watchdog outside stop ignored, inside stop wakes at once
        por();
        wr(4'hF, 8'h0B, 8'h03);
        drive(3'd0, 1'b0, 1'b0, 1'b0);
        wdt_timeout = 1'b1; @(negedge clk); wdt_timeout = 1'b0;
        chk("R9 wdt while running ignored", int'(rec_reset), 0);
        chk("R9 flag clear after running wdt", int'(bus_rdata), 0);
        enter_stop();
        wdt_timeout = 1'b1; @(negedge clk); wdt_timeout = 1'b0;
        chk("R9 wdt in stop wakes", int'(rec_reset), 1);
        chk("R10 gate dropped with wake", int'(stop_clk_gate), 0);
        count_rec(n);
        chk("R10 short delay length", n, 16);
        chk("R11 flag set", int'(bus_rdata), 8'h80);
        chk("R12 clk_div kept", int'(clk_div), 3);
        enter_stop();
        chk("R11 flag sticky in stop", int'(rec_flag), 1);
        wdt_timeout = 1'b1; @(negedge clk); wdt_timeout = 1'b0;
        count_rec(n);
        chk("R11 flag sticky after second wake", int'(rec_flag), 1);
        por();
        chk("R11 power-on clears flag", int'(bus_rdata), 0);
        chk("R12 power-on clears divider", int'(clk_div), 0);

        // R10: long delay
        wr(4'hF, 8'h0B, 8'h20);
        enter_stop();
        wdt_timeout = 1'b1; @(negedge clk); wdt_timeout = 1'b0;
        count_rec(n);
        chk("R10 long delay length", n, 1024);
        chk("R10 back to run", int'(stop_clk_gate), 0);

        // R13: watchdog and completing pin filter in the same cycle
        por();
        wr(4'hF, 8'h0B, 8'h00);
        enter_stop();
        wake_pin = 1'b0;
        repeat (3) @(negedge clk);
        wdt_timeout = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0;
        wake_pin = 1'b1;
        chk("R13 coincident wake", int'(rec_reset), 1);
        count_rec(n);
        chk("R13 single delay length", n, 16);
        chk("R13 gate low after", int'(stop_clk_gate), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule